// File: doc/BRIEF.md
# Peripheral DMA Channel Pointer and Counter

This block keeps the address and count state of one peripheral DMA channel. The state is an active memory pointer and an active transfer counter, plus a standby pointer and counter that hold the following buffer. Software loads these registers through a single-cycle write port. A sequencer pulses `xfer_done` once for each data item it has moved. On each pulse the active pointer advances by the transfer size and the active counter drops by one.

When the active counter runs out, the channel raises its end-of-buffer flag. If the standby counter holds a nonzero count, the block moves the standby pair into the active pair and clears the standby counter, so transfers continue without a gap. If the standby counter is zero, the channel stops and drops its trigger enable. Any write to either counter clears the flag. The transmit and receive directions each use one copy of this block.

Top module: `pdma_chan_regs`

## Requirements
- R1: After reset, the pointers, both counters, the size code and the end flag are zero, and `trig_en_o` is low.
- R2: A `xfer_done` pulse with no write, while the active counter is above one, lowers the counter by one and raises the pointer by the step.
- R3: The size code selects the pointer step. Code 0 gives 1, code 1 gives 2, and codes 2 and 3 give 4.
- R4: A `xfer_done` pulse with no write, while the active counter is one and the standby counter is zero, advances the pointer, sets the counter to zero, drops `trig_en_o` and sets the end flag.
- R5: A `xfer_done` pulse with no write, while the active counter is one and the standby counter is nonzero, sets the end flag and loads the standby pointer and count into the active pair. The standby counter becomes zero.
- R6: A write to the active counter (select 1) or the standby counter (select 3) clears the end flag. Writes to the other selects leave it unchanged.
- R7: When a write and `xfer_done` arrive in the same cycle, only the write takes effect.
- R8: A `xfer_done` pulse while the active counter is zero changes nothing.
- R9: `trig_en_o` is high exactly when the active counter is nonzero.
- R10: A write with `wr_en` high is visible on the outputs one cycle later. Select 0 writes the active pointer, 1 the active counter (low 16 bits), 2 the standby pointer, 3 the standby counter and 4 the size code (low 2 bits). Selects 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| xfer_done | input | 1 | One data item moved |
| ptr_o | output | 32 | Active memory pointer |
| cnt_o | output | 16 | Active transfer counter |
| nxt_ptr_o | output | 32 | Standby pointer |
| nxt_cnt_o | output | 16 | Standby counter |
| size_o | output | 2 | Transfer size code |
| trig_en_o | output | 1 | Trigger enable |
| end_o | output | 1 | End-of-buffer flag |

## Verification
Every register output is due in the cycle after the edge that samples the write or the `xfer_done` pulse. The one exception is `trig_en_o`, which follows the counter directly with no further delay. The bench drives inputs on the falling edge, lets one rising edge pass and compares all outputs on the next falling edge. This ordering makes each comparison see exactly one edge's effect. The chaining case, the stop case, a pulse on an empty counter and a pulse that collides with a write all take this same single-edge path.

// File: rtl/pdma_chan_regs.sv
module pdma_chan_regs #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              xfer_done,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ADDR_W-1:0] nxt_ptr_o,
  output logic [CNT_W-1:0]  nxt_cnt_o,
  output logic [1:0]        size_o,
  output logic              trig_en_o,
  output logic              end_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ADDR_W-1:0] step;
  logic              last;

  assign step      = (size_o == 2'd0) ? ADDR_W'(1) :
                     (size_o == 2'd1) ? ADDR_W'(2) : ADDR_W'(4);
  assign last      = (cnt_o == CNT_ONE);
  assign trig_en_o = (cnt_o != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_o     <= '0;
      cnt_o     <= '0;
      nxt_ptr_o <= '0;
      nxt_cnt_o <= '0;
      size_o    <= '0;
      end_o     <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        3'd0: ptr_o     <= wr_data;
        3'd1: cnt_o     <= wr_data[CNT_W-1:0];
        3'd2: nxt_ptr_o <= wr_data;
        3'd3: nxt_cnt_o <= wr_data[CNT_W-1:0];
        3'd4: size_o    <= wr_data[1:0];
        default: ;
      endcase
      if (wr_sel == 3'd1 || wr_sel == 3'd3) end_o <= 1'b0;
    end else if (xfer_done && trig_en_o) begin
      if (last && nxt_cnt_o != '0) begin
        ptr_o     <= nxt_ptr_o;
        cnt_o     <= nxt_cnt_o;
        nxt_cnt_o <= '0;
      end else begin
        ptr_o <= ptr_o + step;
        cnt_o <= cnt_o - CNT_ONE;
      end
      if (last) end_o <= 1'b1;
    end
  end

endmodule

// File: rtl/pdma_chan_regs_chk.sv
module pdma_chan_regs_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        wr_sel,
  input logic [ADDR_W-1:0] wr_data,
  input logic              xfer_done,
  input logic [ADDR_W-1:0] ptr_o,
  input logic [CNT_W-1:0]  cnt_o,
  input logic [ADDR_W-1:0] nxt_ptr_o,
  input logic [CNT_W-1:0]  nxt_cnt_o,
  input logic [1:0]        size_o,
  input logic              trig_en_o,
  input logic              end_o
);

  // R2
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && xfer_done && cnt_o > CNT_W'(1)) |=> cnt_o == $past(cnt_o) - CNT_W'(1));

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && xfer_done && cnt_o > CNT_W'(1)) |=>
      (ptr_o - $past(ptr_o)) == (($past(size_o) == 2'd0) ? ADDR_W'(1) :
                                 ($past(size_o) == 2'd1) ? ADDR_W'(2) : ADDR_W'(4)));

  // R4
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && xfer_done && cnt_o == CNT_W'(1) && nxt_cnt_o == '0) |=>
      (cnt_o == '0 && !trig_en_o && end_o));

  // R5
  chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && xfer_done && cnt_o == CNT_W'(1) && nxt_cnt_o != '0) |=>
      (cnt_o == $past(nxt_cnt_o) && ptr_o == $past(nxt_ptr_o) && nxt_cnt_o == '0 && end_o));

  // R6
  end_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_sel == 3'd1 || wr_sel == 3'd3)) |=> !end_o);

  // R7
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0) |=> ptr_o == $past(wr_data));

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && cnt_o == '0) |=> ($stable(ptr_o) && cnt_o == '0 && $stable(end_o)));

endmodule

bind pdma_chan_regs pdma_chan_regs_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .xfer_done(xfer_done), .ptr_o(ptr_o), .cnt_o(cnt_o), .nxt_ptr_o(nxt_ptr_o),
  .nxt_cnt_o(nxt_cnt_o), .size_o(size_o), .trig_en_o(trig_en_o), .end_o(end_o));

// File: tb/pdma_chan_regs_bench.sv
module pdma_chan_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [31:0] wr_data;
  logic        xfer_done;
  logic [31:0] ptr_o, nxt_ptr_o;
  logic [15:0] cnt_o, nxt_cnt_o;
  logic [1:0]  size_o;
  logic        trig_en_o, end_o;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  pdma_chan_regs u_pdma_chan_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .xfer_done(xfer_done), .ptr_o(ptr_o), .cnt_o(cnt_o), .nxt_ptr_o(nxt_ptr_o),
    .nxt_cnt_o(nxt_cnt_o), .size_o(size_o), .trig_en_o(trig_en_o), .end_o(end_o));

  typedef struct packed {
    logic        we;
    logic [2:0]  sel;
    logic [31:0] data;
    logic        done;
    logic [31:0] e_ptr;
    logic [15:0] e_cnt;
    logic [15:0] e_ncnt;
    logic        e_end;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 3'd4, 32'h2,      1'b0, 32'h0,    16'd0, 16'd0, 1'b0, 8'd10},
    '{1'b1, 3'd0, 32'h1000,   1'b0, 32'h1000, 16'd0, 16'd0, 1'b0, 8'd10},
    '{1'b1, 3'd1, 32'h3,      1'b0, 32'h1000, 16'd3, 16'd0, 1'b0, 8'd10},
    '{1'b0, 3'd0, 32'h0,      1'b1, 32'h1004, 16'd2, 16'd0, 1'b0, 8'd2},
    '{1'b0, 3'd0, 32'h0,      1'b1, 32'h1008, 16'd1, 16'd0, 1'b0, 8'd2},
    '{1'b1, 3'd2, 32'h2000,   1'b0, 32'h1008, 16'd1, 16'd0, 1'b0, 8'd10},
    '{1'b1, 3'd3, 32'h2,      1'b0, 32'h1008, 16'd1, 16'd2, 1'b0, 8'd10},
    '{1'b0, 3'd0, 32'h0,      1'b1, 32'h2000, 16'd2, 16'd0, 1'b1, 8'd5},
    '{1'b1, 3'd4, 32'h0,      1'b0, 32'h2000, 16'd2, 16'd0, 1'b1, 8'd6},
    '{1'b0, 3'd0, 32'h0,      1'b1, 32'h2001, 16'd1, 16'd0, 1'b1, 8'd3},
    '{1'b0, 3'd0, 32'h0,      1'b1, 32'h2002, 16'd0, 16'd0, 1'b1, 8'd4},
    '{1'b0, 3'd0, 32'h0,      1'b1, 32'h2002, 16'd0, 16'd0, 1'b1, 8'd8},
    '{1'b1, 3'd1, 32'h1,      1'b0, 32'h2002, 16'd1, 16'd0, 1'b0, 8'd6},
    '{1'b1, 3'd0, 32'h3000,   1'b1, 32'h3000, 16'd1, 16'd0, 1'b0, 8'd7},
    '{1'b1, 3'd4, 32'h1,      1'b0, 32'h3000, 16'd1, 16'd0, 1'b0, 8'd3},
    '{1'b0, 3'd0, 32'h0,      1'b1, 32'h3002, 16'd0, 16'd0, 1'b1, 8'd4},
    '{1'b1, 3'd3, 32'h5,      1'b0, 32'h3002, 16'd0, 16'd5, 1'b0, 8'd6},
    '{1'b1, 3'd5, 32'hFFFF,   1'b0, 32'h3002, 16'd0, 16'd5, 1'b0, 8'd10}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] sel, input logic [31:0] d, input logic dn);
    wr_en = we; wr_sel = sel; wr_data = d; xfer_done = dn;
    @(negedge clk);
    wr_en = 1'b0; xfer_done = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ptr", 64'(ptr_o), 64'h0);
    chk("R1 cnt/ncnt/size/end/trig", 64'({cnt_o, nxt_cnt_o, size_o, end_o, trig_en_o}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].we, TBL[i].sel, TBL[i].data, TBL[i].done);
      chk($sformatf("R%0d vec%0d ptr", TBL[i].req, i), 64'(ptr_o), 64'(TBL[i].e_ptr));
      chk($sformatf("R%0d vec%0d cnt", TBL[i].req, i), 64'(cnt_o), 64'(TBL[i].e_cnt));
      chk($sformatf("R%0d vec%0d ncnt", TBL[i].req, i), 64'(nxt_cnt_o), 64'(TBL[i].e_ncnt));
      chk($sformatf("R%0d vec%0d end", TBL[i].req, i), 64'(end_o), 64'(TBL[i].e_end));
      // R9 trigger follows counter
      chk("R9 trig", 64'(trig_en_o), 64'(TBL[i].e_cnt != 0));
    end

    // R3 size code 3 steps by 4
    step(1'b1, 3'd4, 32'h3, 1'b0);
    step(1'b1, 3'd1, 32'h2, 1'b0);
    step(1'b0, 3'd0, 32'h0, 1'b1);
    chk("R3 size3 step", 64'(ptr_o), 64'h3006);
    // R10 counter takes low bits only
    step(1'b1, 3'd1, 32'hABCD_0007, 1'b0);
    chk("R10 cnt low bits", 64'(cnt_o), 64'h7);
    // R10 standby pointer write
    step(1'b1, 3'd2, 32'h4444, 1'b0);
    chk("R10 nxt ptr", 64'(nxt_ptr_o), 64'h4444);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset again", 64'({ptr_o, cnt_o, trig_en_o}), 64'h0);
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule